// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Lookup

This block resolves a 32-bit destination address to a next-hop index by comparing it against a small table of ternary entries in a single parallel step. Each table slot holds a prefix value, a care mask, a valid flag and a next-hop index. Software writes one slot per cycle by giving its index, a prefix and a prefix length. The block turns that length into a mask that cares about the top bits and leaves the low bits as don't-care.

Lookups are pipelined in two register stages. The first stage compares every valid slot against the key at once and keeps the resulting match vector. The second stage picks the lowest-numbered matching slot. The block accepts one key per cycle. The table is kept in order of decreasing prefix length, so the lowest matching slot is the most specific route. A slot holding length 0 matches every address and serves as the default route when it is placed last.

Top module: `tcam_lpm_lookup`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` and `res_hit` are 0 and every table slot is invalid.
- R2: A write with prefix length L cares about address bits [31:32-L] and ignores the rest; a length above 32 behaves as 32, and a length of 0 cares about no bit.
- R3: A valid slot matches a key when every cared bit of the stored prefix equals the same bit of the key; the bits that are not cared about never affect the result.
- R4: When several slots match, the result reports the one with the lowest index, whatever its prefix length, and `res_idx` gives that index.
- R5: A valid slot of length 0 matches any address and is returned only when no lower-indexed slot matches.
- R6: Invalid slots never match; a lookup with no matching slot returns `res_hit`=0, `res_nexthop`=0 and `res_idx`=0.
- R7: A key presented with `lk_valid` at clock edge k produces its result with `res_valid`=1 after edge k+1, a new key is accepted at every edge, and `res_valid` is 0 for cycles with no key.
- R8: A write and a lookup at the same edge: the lookup sees the table as it was before the write, and a lookup at the next edge sees the written slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table slot this cycle |
| wr_idx | input | IDX_W | Slot index to write |
| wr_valid | input | 1 | Valid flag stored with the slot |
| wr_prefix | input | 32 | Prefix value, bits below the length are dropped |
| wr_plen | input | 6 | Prefix length 0 to 32, larger values saturate to 32 |
| wr_nexthop | input | NH_W | Next-hop index stored with the slot |
| lk_valid | input | 1 | A lookup key is presented |
| lk_key | input | 32 | Destination address to resolve |
| res_valid | output | 1 | Result for the key given two edges earlier |
| res_hit | output | 1 | At least one slot matched |
| res_idx | output | IDX_W | Index of the winning slot, 0 on a miss |
| res_nexthop | output | NH_W | Next hop of the winning slot, 0 on a miss |

## Verification
The hardest case to reach from the ports is a write that lands on the very slot a lookup compares at the same edge. Close behind it is a lookup whose winner is rewritten while that lookup is still in the second stage. The bench reaches the first with a directed pair: a key resolves to the default route while a more specific slot is written in the same cycle, and the identical key follows one cycle later. A long random phase then mixes writes to random slots with back-to-back lookups on keys drawn near the stored prefixes. A behavioural model compares every cycle, so the rewrite-in-flight case also occurs many times.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;

  localparam int KEY_W  = 32;
  localparam int PLEN_W = $clog2(KEY_W + 1);

  // Care mask for a prefix length: top plen bits set, saturating at KEY_W.
  function automatic logic [KEY_W-1:0] plen_to_mask(input logic [PLEN_W-1:0] plen);
    logic [KEY_W-1:0] m;
    m = '0;
    for (int b = 0; b < KEY_W; b++) begin
      if (b + int'(plen) >= KEY_W) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Ternary compare of one slot against a key.
  function automatic logic slot_hit(input logic             valid,
                                    input logic [KEY_W-1:0] value,
                                    input logic [KEY_W-1:0] mask,
                                    input logic [KEY_W-1:0] key);
    return valid && (((key ^ value) & mask) == '0);
  endfunction

endpackage

// File: rtl/tcam_slot_table.sv
module tcam_slot_table
  import tcam_lpm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NH_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_valid,
  input  logic [KEY_W-1:0]               wr_prefix,
  input  logic [PLEN_W-1:0]              wr_plen,
  input  logic [NH_W-1:0]                wr_nexthop,
  output logic [ENTRIES-1:0]             slot_valid,
  output logic [ENTRIES-1:0][KEY_W-1:0]  slot_value,
  output logic [ENTRIES-1:0][KEY_W-1:0]  slot_mask,
  output logic [ENTRIES-1:0][NH_W-1:0]   slot_nh
);

  logic [KEY_W-1:0] new_mask;
  logic [KEY_W-1:0] new_value;

  always_comb begin
    new_mask  = plen_to_mask(wr_plen);
    new_value = wr_prefix & new_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= '0;
      slot_value <= '0;
      slot_mask  <= '0;
      slot_nh    <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          slot_valid[i] <= wr_valid;
          slot_value[i] <= new_value;
          slot_mask[i]  <= new_mask;
          slot_nh[i]    <= wr_nexthop;
        end
      end
    end
  end

endmodule

// File: rtl/tcam_compare_stage.sv
module tcam_compare_stage
  import tcam_lpm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NH_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_valid,
  input  logic [KEY_W-1:0]               lk_key,
  input  logic [ENTRIES-1:0]             slot_valid,
  input  logic [ENTRIES-1:0][KEY_W-1:0]  slot_value,
  input  logic [ENTRIES-1:0][KEY_W-1:0]  slot_mask,
  input  logic [ENTRIES-1:0][NH_W-1:0]   slot_nh,
  output logic                           s1_valid,
  output logic [ENTRIES-1:0]             s1_match,
  output logic [ENTRIES-1:0][NH_W-1:0]   s1_nh
);

  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = slot_hit(slot_valid[i], slot_value[i], slot_mask[i], lk_key);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_match <= '0;
      s1_nh    <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) begin
        s1_match <= hit_vec;
        s1_nh    <= slot_nh;
      end else begin
        s1_match <= '0;
      end
    end
  end

endmodule

// File: rtl/tcam_prio_stage.sv
module tcam_prio_stage #(
  parameter int ENTRIES = 16,
  parameter int NH_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          s1_valid,
  input  logic [ENTRIES-1:0]            s1_match,
  input  logic [ENTRIES-1:0][NH_W-1:0]  s1_nh,
  output logic                          res_valid,
  output logic                          res_hit,
  output logic [IDX_W-1:0]              res_idx,
  output logic [NH_W-1:0]               res_nexthop
);

  logic [IDX_W-1:0] win_idx;
  logic             any_hit;

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (s1_match[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_idx     <= '0;
      res_nexthop <= '0;
    end else begin
      res_valid   <= s1_valid;
      res_hit     <= s1_valid && any_hit;
      res_idx     <= (s1_valid && any_hit) ? win_idx : '0;
      res_nexthop <= (s1_valid && any_hit) ? s1_nh[win_idx] : '0;
    end
  end

endmodule

// File: rtl/tcam_lpm_lookup.sv
module tcam_lpm_lookup
  import tcam_lpm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NH_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [31:0]       wr_prefix,
  input  logic [5:0]        wr_plen,
  input  logic [NH_W-1:0]   wr_nexthop,
  input  logic              lk_valid,
  input  logic [31:0]       lk_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [NH_W-1:0]   res_nexthop
);

  logic [ENTRIES-1:0]             slot_valid;
  logic [ENTRIES-1:0][KEY_W-1:0]  slot_value;
  logic [ENTRIES-1:0][KEY_W-1:0]  slot_mask;
  logic [ENTRIES-1:0][NH_W-1:0]   slot_nh;

  // Internal events brought out for the checker.
  logic                           s1_valid;
  logic [ENTRIES-1:0]             s1_match;
  logic [ENTRIES-1:0][NH_W-1:0]   s1_nh;

  tcam_slot_table #(.ENTRIES(ENTRIES), .NH_W(NH_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_prefix  (wr_prefix),
    .wr_plen    (PLEN_W'(wr_plen)),
    .wr_nexthop (wr_nexthop),
    .slot_valid (slot_valid),
    .slot_value (slot_value),
    .slot_mask  (slot_mask),
    .slot_nh    (slot_nh)
  );

  tcam_compare_stage #(.ENTRIES(ENTRIES), .NH_W(NH_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_key     (lk_key),
    .slot_valid (slot_valid),
    .slot_value (slot_value),
    .slot_mask  (slot_mask),
    .slot_nh    (slot_nh),
    .s1_valid   (s1_valid),
    .s1_match   (s1_match),
    .s1_nh      (s1_nh)
  );

  tcam_prio_stage #(.ENTRIES(ENTRIES), .NH_W(NH_W)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid),
    .s1_match    (s1_match),
    .s1_nh       (s1_nh),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_idx     (res_idx),
    .res_nexthop (res_nexthop)
  );

endmodule

// File: rtl/tcam_lpm_lookup_chk.sv
module tcam_lpm_lookup_chk #(
  parameter int ENTRIES = 16,
  parameter int NH_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               s1_valid,
  input logic [ENTRIES-1:0] s1_match,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [NH_W-1:0]    res_nexthop
);

  logic [1:0]         warm;
  logic [ENTRIES-1:0] prev_match;
  logic [ENTRIES-1:0] below_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm       <= '0;
      prev_match <= '0;
    end else begin
      if (warm != 2'd2) warm <= warm + 2'd1;
      prev_match <= s1_valid ? s1_match : '0;
    end
  end

  always_comb begin
    below_win = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IDX_W'(i) < res_idx) below_win[i] = 1'b1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!res_valid && !res_hit);
    end
  end

  // R7
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (res_valid == $past(lk_valid, 2)));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_nexthop == '0 && res_idx == '0));

  // R3
  hit_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && res_valid) |-> (res_hit == (|prev_match)));

  // R4
  winner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && res_hit) |-> prev_match[res_idx]);

  // R4
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && res_hit) |-> ((prev_match & below_win) == '0));

endmodule

bind tcam_lpm_lookup tcam_lpm_lookup_chk #(.ENTRIES(ENTRIES), .NH_W(NH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .s1_valid    (s1_valid),
  .s1_match    (s1_match),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_idx     (res_idx),
  .res_nexthop (res_nexthop)
);

// File: tb/tcam_lpm_lookup_tb_top.sv
`timescale 1ns/1ps
module tcam_lpm_lookup_tb_top;

  localparam int ENTRIES = 16;
  localparam int NH_W    = 8;
  localparam int IDX_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic              wr_valid = 1'b0;
  logic [31:0]       wr_prefix = '0;
  logic [5:0]        wr_plen = '0;
  logic [NH_W-1:0]   wr_nexthop = '0;
  logic              lk_valid = 1'b0;
  logic [31:0]       lk_key = '0;
  logic              res_valid;
  logic              res_hit;
  logic [IDX_W-1:0]  res_idx;
  logic [NH_W-1:0]   res_nexthop;

  always #2.5 clk = ~clk;

  tcam_lpm_lookup #(.ENTRIES(ENTRIES), .NH_W(NH_W)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  // Behavioural reference model.
  bit          m_valid [ENTRIES];
  logic [31:0] m_pfx   [ENTRIES];
  int          m_len   [ENTRIES];
  int          m_nh    [ENTRIES];
  bit p1v, p1h, p2v, p2h;
  int p1i, p1n, p2i, p2n;

  function automatic bit pfx_eq(logic [31:0] a, logic [31:0] b, int len);
    int l;
    l = (len > 32) ? 32 : len;
    if (l == 0) return 1;
    return (a >> (32 - l)) == (b >> (32 - l));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
      p1v = 0; p1h = 0; p1i = 0; p1n = 0;
      p2v = 0; p2h = 0; p2i = 0; p2n = 0;
    end else begin
      p2v = p1v; p2h = p1h; p2i = p1i; p2n = p1n;
      p1v = lk_valid; p1h = 0; p1i = 0; p1n = 0;
      if (lk_valid) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (!p1h && m_valid[i] && pfx_eq(lk_key, m_pfx[i], m_len[i])) begin
            p1h = 1; p1i = i; p1n = m_nh[i];
          end
        end
      end
      if (wr_en) begin
        m_valid[wr_idx] = wr_valid;
        m_pfx[wr_idx]   = wr_prefix;
        m_len[wr_idx]   = int'(wr_plen);
        m_nh[wr_idx]    = int'(wr_nexthop);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R7 res_valid", res_valid, p2v);
      if (p2v) begin
        chk("R3/R4 res_hit", res_hit, p2h);
        chk("R4 res_idx", res_idx, p2i);
        chk("R6 res_nexthop", res_nexthop, p2n);
      end
    end
  end

  function automatic logic [31:0] ip(int a, int b, int c, int d);
    return {a[7:0], b[7:0], c[7:0], d[7:0]};
  endfunction

  task automatic put(int idx, bit v, logic [31:0] p, int len, int nh);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_valid = v;
    wr_prefix = p; wr_plen = 6'(len); wr_nexthop = NH_W'(nh);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(string tag, logic [31:0] key, bit eh, int ei, int en);
    @(negedge clk);
    lk_valid = 1; lk_key = key;
    @(negedge clk);
    lk_valid = 0;
    @(negedge clk);
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " hit"}, res_hit, eh);
    chk({tag, " idx"}, res_idx, ei);
    chk({tag, " nexthop"}, res_nexthop, en);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset res_valid", res_valid, 0);
    chk("R1 reset res_hit", res_hit, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1: empty table after reset misses
    look("R1 empty", ip(10,1,2,3), 0, 0, 0);

    put(0, 1, ip(10,1,2,99), 24, 11);
    put(1, 1, ip(10,1,0,0), 16, 12);
    put(2, 1, ip(10,0,0,0), 8, 13);
    put(3, 1, ip(192,168,0,0), 16, 14);
    put(4, 0, ip(172,16,0,0), 12, 15);
    put(5, 1, ip(10,1,2,77), 32, 16);

    look("R2 len24", ip(10,1,2,9), 1, 0, 11);
    look("R2 len16", ip(10,1,7,1), 1, 1, 12);
    look("R2 len8", ip(10,200,0,1), 1, 2, 13);
    look("R3 dontcare", ip(192,168,255,255), 1, 3, 14);
    look("R3 cared bit", ip(192,169,0,0), 0, 0, 0);
    look("R6 invalid slot", ip(172,16,5,5), 0, 0, 0);
    look("R4 position wins", ip(10,1,2,77), 1, 0, 11);

    put(15, 1, ip(1,2,3,4), 0, 99);
    look("R5 default", ip(172,16,5,5), 1, 15, 99);
    look("R5 default any", ip(255,255,255,255), 1, 15, 99);
    look("R5 default loses", ip(10,9,9,9), 1, 2, 13);

    put(6, 1, ip(1,2,3,4), 40, 21);
    look("R2 saturate hit", ip(1,2,3,4), 1, 6, 21);
    look("R2 saturate miss", ip(1,2,3,5), 1, 15, 99);

    // R8: write and lookup in the same cycle, then the same key again.
    @(negedge clk);
    lk_valid = 1; lk_key = ip(8,8,8,8);
    wr_en = 1; wr_idx = 4'd7; wr_valid = 1;
    wr_prefix = ip(8,0,0,0); wr_plen = 6'd8; wr_nexthop = 8'd30;
    @(negedge clk);
    wr_en = 0; lk_key = ip(8,8,8,8);
    @(negedge clk);
    lk_valid = 0;
    chk("R8 old table hit", res_hit, 1);
    chk("R8 old table idx", res_idx, 15);
    chk("R8 old table nexthop", res_nexthop, 99);
    @(negedge clk);
    chk("R8 new table idx", res_idx, 7);
    chk("R8 new table nexthop", res_nexthop, 30);
    chk("R7 back-to-back valid", res_valid, 1);
    @(negedge clk);
    chk("R7 idle valid", res_valid, 0);

    // Random mix of writes and lookups, checked by the model every cycle.
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lk_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 4))
        0: lk_key = ip(10, 1, 2, $urandom_range(0, 255));
        1: lk_key = ip(10, 1, $urandom_range(0, 3), $urandom_range(0, 255));
        2: lk_key = ip(10, $urandom_range(0, 255), 0, 1);
        3: lk_key = ip(192, 168 + $urandom_range(0, 1), 0, 0);
        default: lk_key = $urandom;
      endcase
      wr_en = ($urandom_range(0, 7) == 0);
      wr_idx = IDX_W'($urandom_range(0, ENTRIES - 1));
      wr_valid = ($urandom_range(0, 3) != 0);
      wr_prefix = ($urandom_range(0, 1) != 0) ? ip(10, 1, $urandom_range(0, 3), 0) : $urandom;
      wr_plen = 6'($urandom_range(0, 40));
      wr_nexthop = NH_W'($urandom_range(1, 255));
    end
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule